// File: doc/BRIEF.md
# Prioritized Interrupt Controller with End-of-Interrupt Handling

This block gathers interrupt requests from a group of timers and from several other sources, ranks them by a programmable 3-bit level, and drives a single interrupt line toward a processor. Each source entry has its own control word that holds a disable flag and a level. The controller records which requests are waiting and which are being serviced. It derives a blocking level from the highest-ranked entry in service, so an equal or lower request cannot interrupt a handler that is already running.

Software reaches the block through a small word-wide register window. A request is taken either by pulsing the acknowledge pin, which also returns the vector type, or by reading the acknowledging poll word. A second poll word reports the same pending flag and vector but changes nothing. A handler ends with an end-of-interrupt write. This write either names a vector or asks the block to retire whichever in-service entry ranks highest. The timers share entry 0 and one level. A status word shows which timer is waiting, and each timer keeps its own vector.

Top module: `pic_ctrl`

## Requirements
- R1: After reset every control word reads 0x000F (disabled, level 7), the request, in-service and timer status words read 0, the blocking level reads 8 (nothing in service) and `irq_out` is low.
- R2: The control word of entry e sits at address e, with bit 3 the disable flag and bits 2:0 the level. Address 10 is read-only and returns the disable flags of all entries, bit e for entry e.
- R3: A request input sets its entry's bit in the request word (address 8) even while the entry is disabled. A disabled entry never drives `irq_out`.
- R4: The poll-status word (address 13) returns the pending flag in bit 15 and a vector in bits 7:0. The vector belongs to the enabled waiting entry with the numerically smallest level; on a tie the lower entry index wins. Entry k≥1 has vector VEC_BASE+NTMR-1+k.
- R5: Reading poll-status changes neither the request word nor the in-service word (address 9).
- R6: Reading the poll word (address 12) returns the same format as poll-status. When the pending flag is set, the read also acknowledges: it sets the entry's in-service bit, clears its request bit, and the blocking level (address 11) becomes that entry's level.
- R7: While `inta` is high, `inta_vec` shows the vector of the winning request. An `inta` pulse acknowledges it exactly as R6 does.
- R8: `irq_out` is high exactly when the best enabled waiting level is strictly smaller than the blocking level. A request at the blocking level or below it waits.
- R9: An end-of-interrupt write to address 14 with bit 15 set clears only the in-service bit of the highest-ranked in-service entry.
- R10: An end-of-interrupt write with bit 15 clear clears only the in-service bit of the entry whose vector is in bits 7:0. A vector that matches no entry changes nothing.
- R11: The NTMR timers share entry 0. The timer status word (address 15) holds one bit per timer. A bit is set by that timer's request and cleared when the entry is acknowledged for that timer. The lowest-numbered waiting timer is served first, and timer t has vector VEC_BASE+t. Its vector also works as a specific end-of-interrupt code for entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| tmr_req | input | NTMR | Timer request pulses |
| src_req | input | NSRC-1 | Request pulses of entries 1 to NSRC-1 |
| inta | input | 1 | Hardware acknowledge pulse |
| inta_vec | output | 8 | Vector type of the winning request |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
Single requests show that the disable flag and the level gate the line independently. Two requests at different levels test ranking. Two requests at the same level test the lower-index tie rule and the strict blocking by the in-service level. Alternating poll-status and poll reads show that only one of them acknowledges. End-of-interrupt writes come in three forms: nonspecific with two entries in service, specific with a valid vector, and specific with a stray vector. Two timers raised together show that they share entry 0, are served lowest number first, and keep separate vectors.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int PRIO_W   = 3;
   localparam int LVL_W    = PRIO_W + 1;
   localparam int DATA_W   = 16;
   localparam int ADDR_W   = 4;
   localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(1 << PRIO_W);

   localparam logic [ADDR_W-1:0] A_REQ   = 4'd8;
   localparam logic [ADDR_W-1:0] A_ISR   = 4'd9;
   localparam logic [ADDR_W-1:0] A_MASK  = 4'd10;
   localparam logic [ADDR_W-1:0] A_LEVEL = 4'd11;
   localparam logic [ADDR_W-1:0] A_POLL  = 4'd12;
   localparam logic [ADDR_W-1:0] A_PSTAT = 4'd13;
   localparam logic [ADDR_W-1:0] A_EOI   = 4'd14;
   localparam logic [ADDR_W-1:0] A_TSTAT = 4'd15;

   localparam int CTL_DIS_BIT = 3;
   localparam int EOI_NS_BIT  = 15;
   localparam int FLAG_BIT    = 15;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick
   import pic_pkg::*;
#(
   parameter int N  = 7,
   parameter int IW = 3
) (
   input  logic [N-1:0]        cand,
   input  logic [N*PRIO_W-1:0] prio_flat,
   output logic                valid,
   output logic [IW-1:0]       idx,
   output logic [PRIO_W-1:0]   lvl
);
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      lvl   = '1;
      for (int i = 0; i < N; i++) begin
         if (cand[i] && (!valid || (prio_flat[i*PRIO_W +: PRIO_W] < lvl))) begin
            valid = 1'b1;
            idx   = IW'(i);
            lvl   = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/pic_tmr_group.sv
module pic_tmr_group #(
   parameter int NTMR = 3,
   parameter int TW   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NTMR-1:0] tmr_req,
   input  logic            ack,
   output logic [NTMR-1:0] tstat,
   output logic [TW-1:0]   sel,
   output logic            any
);
   logic [NTMR-1:0] clr;

   always_comb begin
      sel = '0;
      for (int t = NTMR - 1; t >= 0; t--) begin
         if (tstat[t]) sel = TW'(t);
      end
   end

   assign any = |tstat;
   assign clr = ack ? (NTMR'(1) << sel) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) tstat <= '0;
      else        tstat <= (tstat & ~clr) | tmr_req;
   end
endmodule

// File: rtl/pic_eoi_decode.sv
module pic_eoi_decode
   import pic_pkg::*;
#(
   parameter int         NSRC     = 7,
   parameter int         NTMR     = 3,
   parameter int         IW       = 3,
   parameter logic [7:0] VEC_BASE = 8'h11
) (
   input  logic              eoi_wr,
   input  logic [DATA_W-1:0] eoi_data,
   input  logic              top_valid,
   input  logic [IW-1:0]     top_idx,
   output logic [NSRC-1:0]   clr
);
   localparam logic [7:0] T_END = 8'(NTMR);
   localparam logic [7:0] S_END = 8'(NTMR + NSRC - 1);

   logic [7:0] off;
   logic [7:0] ent8;
   logic       unused_hi;

   assign off       = eoi_data[7:0] - VEC_BASE;
   assign ent8      = off - T_END + 8'd1;
   assign unused_hi = ^eoi_data[EOI_NS_BIT-1:8];

   always_comb begin
      clr = '0;
      if (eoi_wr) begin
         if (eoi_data[EOI_NS_BIT]) begin
            if (top_valid) clr[top_idx] = 1'b1;
         end else if (off < T_END) begin
            clr[0] = 1'b1;
         end else if (off < S_END) begin
            clr[IW'(ent8)] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
   import pic_pkg::*;
#(
   parameter int         NSRC     = 7,
   parameter int         NTMR     = 3,
   parameter logic [7:0] VEC_BASE = 8'h11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NTMR-1:0]      tmr_req,
   input  logic [NSRC-2:0]      src_req,
   input  logic                 inta,
   output logic [7:0]           inta_vec,
   output logic                 irq_out
);
   localparam int IW = $clog2(NSRC);
   localparam int TW = (NTMR > 1) ? $clog2(NTMR) : 1;

   if (NSRC < 2 || NSRC > 8) begin : g_bad_nsrc
      $error("pic_ctrl: NSRC must lie in 2..8");
   end
   if (NTMR < 1 || NTMR > 8) begin : g_bad_ntmr
      $error("pic_ctrl: NTMR must lie in 1..8");
   end
   if (int'(VEC_BASE) + NTMR + NSRC - 1 > 256) begin : g_bad_vec
      $error("pic_ctrl: vector range exceeds 8 bits");
   end

   logic [NSRC-1:0]        mask_q;
   logic [NSRC*PRIO_W-1:0] prio_q;
   logic [NSRC-1:0]        req_vec;
   logic [NSRC-1:0]        isr_q;
   logic [NSRC-1:0]        isr_set;
   logic [NSRC-1:0]        isr_clr;

   logic                   p_valid, s_valid;
   logic [IW-1:0]          p_idx, s_idx;
   logic [PRIO_W-1:0]      p_lvl, s_lvl;
   logic [LVL_W-1:0]       pmask;
   logic                   qualified, ack, poll_rd, eoi_wr;
   logic [NTMR-1:0]        tstat;
   logic [TW-1:0]          t_sel;
   logic                   t_any;
   logic [7:0]             vec;
   logic                   unused_wbits;

   assign unused_wbits = ^bus_wdata[DATA_W-1:CTL_DIS_BIT+1];

   // control words, one per entry
   for (genvar e = 0; e < NSRC; e++) begin : g_ctl
      logic wr_here;
      assign wr_here = bus_sel && bus_wr && (bus_addr == ADDR_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[e]                  <= 1'b1;
            prio_q[e*PRIO_W +: PRIO_W] <= '1;
         end else if (wr_here) begin
            mask_q[e]                  <= bus_wdata[CTL_DIS_BIT];
            prio_q[e*PRIO_W +: PRIO_W] <= bus_wdata[PRIO_W-1:0];
         end
      end
   end

   // shared timer entry
   pic_tmr_group #(.NTMR(NTMR), .TW(TW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tmr_req (tmr_req),
      .ack     (ack && (p_idx == '0)),
      .tstat   (tstat),
      .sel     (t_sel),
      .any     (t_any)
   );
   assign req_vec[0] = t_any;

   // request latches of the remaining entries
   for (genvar k = 1; k < NSRC; k++) begin : g_req
      logic r_q;
      always_ff @(posedge clk) begin
         if (!rst_n) r_q <= 1'b0;
         else        r_q <= (r_q && !(ack && (p_idx == IW'(k)))) || src_req[k-1];
      end
      assign req_vec[k] = r_q;
   end

   // ranking of waiting requests and of in-service entries
   pic_prio_pick #(.N(NSRC), .IW(IW)) u_pend (
      .cand      (req_vec & ~mask_q),
      .prio_flat (prio_q),
      .valid     (p_valid),
      .idx       (p_idx),
      .lvl       (p_lvl)
   );

   pic_prio_pick #(.N(NSRC), .IW(IW)) u_serv (
      .cand      (isr_q),
      .prio_flat (prio_q),
      .valid     (s_valid),
      .idx       (s_idx),
      .lvl       (s_lvl)
   );

   assign pmask     = s_valid ? {1'b0, s_lvl} : LVL_IDLE;
   assign qualified = p_valid && ({1'b0, p_lvl} < pmask);
   assign irq_out   = qualified;

   assign poll_rd = bus_sel && !bus_wr && (bus_addr == A_POLL);
   assign eoi_wr  = bus_sel &&  bus_wr && (bus_addr == A_EOI);
   assign ack     = qualified && (inta || poll_rd);

   assign vec      = (p_idx == '0) ? (VEC_BASE + 8'(t_sel))
                                   : (VEC_BASE + 8'(NTMR - 1) + 8'(p_idx));
   assign inta_vec = vec;

   pic_eoi_decode #(.NSRC(NSRC), .NTMR(NTMR), .IW(IW), .VEC_BASE(VEC_BASE)) u_eoi (
      .eoi_wr    (eoi_wr),
      .eoi_data  (bus_wdata),
      .top_valid (s_valid),
      .top_idx   (s_idx),
      .clr       (isr_clr)
   );

   assign isr_set = ack ? (NSRC'(1) << p_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~isr_clr) | isr_set;
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      for (int e = 0; e < NSRC; e++) begin
         if (bus_addr == ADDR_W'(e)) begin
            bus_rdata[CTL_DIS_BIT]  = mask_q[e];
            bus_rdata[PRIO_W-1:0]   = prio_q[e*PRIO_W +: PRIO_W];
         end
      end
      case (bus_addr)
         A_REQ:   bus_rdata[NSRC-1:0] = req_vec;
         A_ISR:   bus_rdata[NSRC-1:0] = isr_q;
         A_MASK:  bus_rdata[NSRC-1:0] = mask_q;
         A_LEVEL: bus_rdata[LVL_W-1:0] = pmask;
         A_POLL, A_PSTAT: begin
            bus_rdata[FLAG_BIT] = qualified;
            bus_rdata[7:0]      = vec;
         end
         A_TSTAT: bus_rdata[NTMR-1:0] = tstat;
         default: ;
      endcase
   end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
   import pic_pkg::*;
#(
   parameter int NSRC = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_out,
   input logic             ack,
   input logic             eoi_wr,
   input logic [NSRC-1:0]  req_vec,
   input logic [NSRC-1:0]  isr,
   input logic [LVL_W-1:0] pmask
);
   a_r6_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (isr != '0));

   a_r6_level_tightens: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (pmask < $past(pmask)));

   a_r8_line_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (req_vec != '0));

   a_r8_top_level_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
      (pmask == '0) |-> !irq_out);

   a_r9_eoi_never_adds: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !ack) |=> ($countones(isr) <= $countones($past(isr))));
endmodule

bind pic_ctrl pic_ctrl_chk #(.NSRC(NSRC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_out (irq_out),
   .ack     (ack),
   .eoi_wr  (eoi_wr),
   .req_vec (req_vec),
   .isr     (isr_q),
   .pmask   (pmask)
);

// File: tb/pic_ctrl_test.sv
module pic_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [2:0]  tmr_req = '0;
   logic [5:0]  src_req = '0;
   logic        inta = 1'b0;
   logic [7:0]  inta_vec;
   logic        irq_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pic_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tmr_req(tmr_req), .src_req(src_req), .inta(inta),
      .inta_vec(inta_vec), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
      logic [15:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic pulse_src(input logic [5:0] v);
      @(negedge clk); src_req = v;
      @(negedge clk); src_req = '0;
   endtask

   task automatic pulse_tmr(input logic [2:0] v);
      @(negedge clk); tmr_req = v;
      @(negedge clk); tmr_req = '0;
   endtask

   task automatic t_reset;
      chk("R1 irq low", {15'b0, irq_out}, 16'h0000);
      rd_chk("R1 ctl0", 4'd0, 16'h000F);
      rd_chk("R1 ctl6", 4'd6, 16'h000F);
      rd_chk("R1 req", 4'd8, 16'h0000);
      rd_chk("R1 isr", 4'd9, 16'h0000);
      rd_chk("R1 level", 4'd11, 16'h0008);
      rd_chk("R1 tstat", 4'd15, 16'h0000);
      rd_chk("R2 mask mirror reset", 4'd10, 16'h007F);
   endtask

   task automatic t_mask_and_status;
      pulse_src(6'b000001);
      rd_chk("R3 req while disabled", 4'd8, 16'h0002);
      chk("R3 disabled keeps line low", {15'b0, irq_out}, 16'h0000);
      wr(4'd1, 16'h0005);
      rd_chk("R2 ctl1 readback", 4'd1, 16'h0005);
      rd_chk("R2 mask mirror", 4'd10, 16'h007D);
      chk("R8 line up", {15'b0, irq_out}, 16'h0001);
      rd_chk("R4 pstat", 4'd13, 16'h8014);
      rd_chk("R5 pstat again", 4'd13, 16'h8014);
      rd_chk("R5 req kept", 4'd8, 16'h0002);
      rd_chk("R5 isr kept", 4'd9, 16'h0000);
   endtask

   task automatic t_poll_and_eoi;
      logic [15:0] v;
      rd_chk("R6 poll", 4'd12, 16'h8014);
      rd_chk("R6 isr set", 4'd9, 16'h0002);
      rd_chk("R6 req cleared", 4'd8, 16'h0000);
      rd_chk("R6 level", 4'd11, 16'h0005);
      wr(4'd2, 16'h0005);
      pulse_src(6'b000010);
      chk("R8 equal level blocked", {15'b0, irq_out}, 16'h0000);
      wr(4'd3, 16'h0002);
      pulse_src(6'b000100);
      chk("R8 higher level passes", {15'b0, irq_out}, 16'h0001);
      @(negedge clk); inta = 1'b1;
      #1 v = {8'h00, inta_vec};
      @(negedge clk); inta = 1'b0;
      chk("R7 inta vector", v, 16'h0016);
      rd_chk("R7 isr after inta", 4'd9, 16'h000A);
      rd_chk("R7 level after inta", 4'd11, 16'h0002);
      rd_chk("R7 other req kept", 4'd8, 16'h0004);
      wr(4'd14, 16'h8000);
      rd_chk("R9 nonspecific", 4'd9, 16'h0002);
      rd_chk("R9 level back", 4'd11, 16'h0005);
      wr(4'd14, 16'h0099);
      rd_chk("R10 stray vector", 4'd9, 16'h0002);
      wr(4'd14, 16'h0014);
      rd_chk("R10 specific", 4'd9, 16'h0000);
      chk("R8 unblocked", {15'b0, irq_out}, 16'h0001);
      rd_chk("R6 poll second", 4'd12, 16'h8015);
      wr(4'd14, 16'h8000);
      rd_chk("R9 cleanup", 4'd9, 16'h0000);
   endtask

   task automatic t_tie;
      wr(4'd4, 16'h0003);
      wr(4'd5, 16'h0003);
      pulse_src(6'b011000);
      rd_chk("R4 tie lower index", 4'd13, 16'h8017);
      rd_chk("R6 poll tie", 4'd12, 16'h8017);
      rd_chk("R8 peer blocked", 4'd13, 16'h0018);
      wr(4'd14, 16'h8000);
      rd_chk("R6 poll peer", 4'd12, 16'h8018);
      wr(4'd14, 16'h8000);
      rd_chk("R9 tie cleanup", 4'd9, 16'h0000);
   endtask

   task automatic t_timer;
      wr(4'd0, 16'h0001);
      pulse_tmr(3'b110);
      rd_chk("R11 tstat", 4'd15, 16'h0006);
      rd_chk("R11 req entry0", 4'd8, 16'h0001);
      rd_chk("R11 pstat timer1", 4'd13, 16'h8012);
      rd_chk("R11 poll timer1", 4'd12, 16'h8012);
      rd_chk("R11 tstat after ack", 4'd15, 16'h0004);
      rd_chk("R11 isr entry0", 4'd9, 16'h0001);
      chk("R8 shared level blocked", {15'b0, irq_out}, 16'h0000);
      wr(4'd14, 16'h0012);
      rd_chk("R10 timer1 eoi", 4'd9, 16'h0000);
      rd_chk("R11 poll timer2", 4'd12, 16'h8013);
      rd_chk("R11 tstat empty", 4'd15, 16'h0000);
      rd_chk("R11 req empty", 4'd8, 16'h0000);
      wr(4'd14, 16'h0013);
      rd_chk("R11 timer2 eoi", 4'd9, 16'h0000);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_mask_and_status;
      t_poll_and_eoi;
      t_tie;
      t_timer;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule